// File: doc/BRIEF.md
# Stereo Attenuation Control Port

This block is a write-only control port for a stereo playback path. It keeps one setting for each channel, made of a 6-bit attenuation code (1 dB per step) and a mute flag. A host sends one control byte at a time over three wires: a serial clock, serial data and a latch strobe. The first bit of the byte picks the channel. The next bit is the mute flag and the remaining six bits are the attenuation code.

Every pin the port sees runs off a single core clock. The three control pins, the left/right frame clock and the external mute pin can be fully asynchronous to it, and each one passes through a two-stage synchroniser before any logic uses it. A byte committed by the strobe does not change the output straight away. It first waits for the next frame-clock edge. After that edge it waits for that channel's own audio to cross zero. If no crossing is seen, it is applied once a fixed number of that channel's samples have gone by. Applying the change at a zero crossing avoids an audible step in the output.

The outputs are the active code and mute flag for each channel. An external mute pin forces both mute outputs high.

Top module: `attn_ctl_port`

## Requirements
- R1: Control data is taken on each rising edge of the serial clock, most significant bit first, and only the last 8 bits shifted in are kept.
- R2: A rising edge of the strobe commits the last 8 shifted bits. If fewer than 8 clock edges have been seen since the previous strobe, the strobe is ignored and the outputs keep their values.
- R3: In the committed byte, bit 7 selects the channel (1 for right, 0 for left), bit 6 is mute (1 means muted) and bits 5:0 are the attenuation code, from 0 (0 dB) to 63 (63 dB).
- R4: After reset, both channels read mute 0 and attenuation 0, with no write needed.
- R5: A committed setting takes no effect before the next edge of the frame clock, rising or falling, that is seen after the commit. Zero crossings that come before that edge do not apply it.
- R6: Once the setting is armed by the frame edge, it becomes active after the first sample of its own channel that is either exactly zero or has a sign bit different from the previous sample of that channel. Samples of the other channel have no effect on it.
- R7: If no crossing arrives, the armed setting becomes active on the 1024th sample of its channel counted from the arming edge (parameter TIMEOUT).
- R8: A new commit to a channel replaces that channel's pending setting and restarts the whole wait, first for a frame edge and then for the crossing or the timeout.
- R9: While the external mute pin is high, both mute outputs are 1 and the attenuation outputs are unchanged. When the pin goes low, the register values show again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_sck | input | 1 | Serial control clock, may be gated |
| ctl_sdi | input | 1 | Serial control data |
| ctl_stb | input | 1 | Commit strobe, rising-edge active |
| frame_clk | input | 1 | Left/right frame clock |
| mute_pin | input | 1 | External mute that covers both channels |
| smp_valid | input | 1 | One-cycle strobe marking a new audio sample |
| smp_right | input | 1 | Channel of the sample (1 = right) |
| smp_data | input | SAMPLE_W | Two's-complement sample value |
| att_l | output | 6 | Active left attenuation code |
| mute_l | output | 1 | Left mute |
| att_r | output | 6 | Active right attenuation code |
| mute_r | output | 1 | Right mute |

## Verification
The hardest cases to reach are those where a setting is pending while the timeout counter is part-way through its count. One case shows that the timeout fires on exactly the 1024th sample. The other shows that a second commit restarts the count instead of letting the first count run out. The stimulus holds one channel's samples at a single sign, so no crossing ever occurs. It sends 1023 samples and then one more to find the exact firing point. It then re-commits after 600 samples and shows that 1200 and 1623 samples leave the output unchanged, while the 1624th sample applies the new value. The frame-edge deferral is shown by sending real crossings after a commit but before any frame edge.

// File: rtl/attn_port_pkg.sv
package attn_port_pkg;

    localparam int WORD_W = 8;
    localparam int ATT_W  = 6;

    // One channel's setting: mute flag above the attenuation code.
    typedef struct packed {
        logic             mute;
        logic [ATT_W-1:0] att;
    } chan_set_t;

    // Control byte layout: channel select on top, then the setting.
    typedef struct packed {
        logic      right;
        chan_set_t set;
    } ctl_word_t;

    localparam chan_set_t SET_DEFAULT = '{mute: 1'b0, att: '0};

    function automatic ctl_word_t to_word(input logic [WORD_W-1:0] b);
        return ctl_word_t'(b);
    endfunction

endpackage

// File: rtl/sync_bus.sv
module sync_bus #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];

endmodule

// File: rtl/ctl_serial_rx.sv
module ctl_serial_rx
    import attn_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_rise,
    input  logic      sdi,
    input  logic      stb_rise,
    output logic      commit_vld,
    output ctl_word_t commit_word
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  nbits;
    logic              full;

    assign full = (nbits == CNT_W'(WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg       <= '0;
            nbits       <= '0;
            commit_vld  <= 1'b0;
            commit_word <= '0;
        end else begin
            commit_vld <= 1'b0;
            if (stb_rise) begin
                // R2: a short byte is dropped, the count restarts either way
                if (full) begin
                    commit_vld  <= 1'b1;
                    commit_word <= to_word(shreg);
                end
                nbits <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[WORD_W-2:0], sdi};   // R1: MSB first
                if (!full) nbits <= nbits + 1'b1;
            end
        end
    end

    a_r2_commit_pulse: assert property (@(posedge clk) disable iff (rst)
        commit_vld |=> !commit_vld);

    a_r2_count_cap: assert property (@(posedge clk) disable iff (rst)
        $past(stb_rise) |-> nbits == '0);

endmodule

// File: rtl/chan_apply.sv
module chan_apply
    import attn_port_pkg::*;
#(
    parameter int SAMPLE_W = 18,
    parameter int TIMEOUT  = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  chan_set_t           commit_set,
    input  logic                frame_edge,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_data,
    output chan_set_t           active
);

    localparam int TCW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [TCW-1:0] T_LAST = TCW'(TIMEOUT - 1);

    chan_set_t      pend;
    logic           waiting;
    logic           armed;
    logic [TCW-1:0] tcnt;
    logic           prev_neg;
    logic           crossing;

    assign crossing = (smp_data == '0) || (smp_data[SAMPLE_W-1] != prev_neg);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= SET_DEFAULT;
            pend     <= SET_DEFAULT;
            waiting  <= 1'b0;
            armed    <= 1'b0;
            tcnt     <= '0;
            prev_neg <= 1'b0;
        end else begin
            if (smp_vld) prev_neg <= smp_data[SAMPLE_W-1];
            if (commit) begin
                // R8: replace pending, restart the full wait
                pend    <= commit_set;
                waiting <= 1'b1;
                armed   <= 1'b0;
                tcnt    <= '0;
            end else if (waiting && frame_edge) begin
                // R5: arm on first frame edge after the commit
                waiting <= 1'b0;
                armed   <= 1'b1;
                tcnt    <= '0;
            end else if (armed && smp_vld) begin
                if (crossing || tcnt == T_LAST) begin   // R6, R7
                    active <= pend;
                    armed  <= 1'b0;
                    tcnt   <= '0;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    a_r5_arm_on_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(frame_edge));

    a_r6_hold_unarmed: assert property (@(posedge clk) disable iff (rst)
        !armed |=> $stable(active));

    a_r7_count_idle: assert property (@(posedge clk) disable iff (rst)
        !armed |-> tcnt == '0);

    a_r8_commit_rewaits: assert property (@(posedge clk) disable iff (rst)
        commit |=> (waiting && !armed));

endmodule

// File: rtl/attn_ctl_port.sv
module attn_ctl_port
    import attn_port_pkg::*;
#(
    parameter int SAMPLE_W    = 18,
    parameter int TIMEOUT     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_sck,
    input  logic                ctl_sdi,
    input  logic                ctl_stb,
    input  logic                frame_clk,
    input  logic                mute_pin,
    input  logic                smp_valid,
    input  logic                smp_right,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [ATT_W-1:0]    att_l,
    output logic                mute_l,
    output logic [ATT_W-1:0]    att_r,
    output logic                mute_r
);

    localparam int NPIN = 5;
    localparam int NCH  = 2;

    logic [NPIN-1:0] pins_s;
    logic [2:0]      edge_prev;
    logic            sck_s, sdi_s, stb_s, frm_s, mute_s;
    logic            sck_rise, stb_rise, frame_edge;
    logic            commit_vld;
    ctl_word_t       commit_word;
    chan_set_t       act [NCH];

    sync_bus #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({mute_pin, frame_clk, ctl_stb, ctl_sdi, ctl_sck}),
        .q   (pins_s)
    );

    assign {mute_s, frm_s, stb_s, sdi_s, sck_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) edge_prev <= '0;
        else     edge_prev <= {frm_s, stb_s, sck_s};
    end

    assign sck_rise   = sck_s & ~edge_prev[0];
    assign stb_rise   = stb_s & ~edge_prev[1];
    assign frame_edge = frm_s ^ edge_prev[2];

    ctl_serial_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .sck_rise    (sck_rise),
        .sdi         (sdi_s),
        .stb_rise    (stb_rise),
        .commit_vld  (commit_vld),
        .commit_word (commit_word)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic sel_commit, sel_smp;
        assign sel_commit = commit_vld && (commit_word.right == ch[0]);
        assign sel_smp    = smp_valid && (smp_right == ch[0]);

        chan_apply #(.SAMPLE_W(SAMPLE_W), .TIMEOUT(TIMEOUT)) u_apply (
            .clk        (clk),
            .rst        (rst),
            .commit     (sel_commit),
            .commit_set (commit_word.set),
            .frame_edge (frame_edge),
            .smp_vld    (sel_smp),
            .smp_data   (smp_data),
            .active     (act[ch])
        );
    end

    // R9: external mute overrides both flags
    assign att_l  = act[0].att;
    assign mute_l = act[0].mute | mute_s;
    assign att_r  = act[1].att;
    assign mute_r = act[1].mute | mute_s;

    a_r4_reset_defaults: assert property (@(posedge clk)
        rst |=> (act[0] == SET_DEFAULT && act[1] == SET_DEFAULT));

endmodule

// File: tb/attn_ctl_port_tb.sv
module attn_ctl_port_tb;

    localparam int SW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_sck = 1'b0, ctl_sdi = 1'b0, ctl_stb = 1'b0;
    logic          frame_clk = 1'b0, mute_pin = 1'b0;
    logic          smp_valid = 1'b0, smp_right = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [5:0]    att_l, att_r;
    logic          mute_l, mute_r;

    int nchk = 0;
    int nfail = 0;
    logic [6:0] exp_l = '0;
    logic [6:0] exp_r = '0;

    always #5 clk = ~clk;

    attn_ctl_port u_dut (
        .clk(clk), .rst(rst), .ctl_sck(ctl_sck), .ctl_sdi(ctl_sdi),
        .ctl_stb(ctl_stb), .frame_clk(frame_clk), .mute_pin(mute_pin),
        .smp_valid(smp_valid), .smp_right(smp_right), .smp_data(smp_data),
        .att_l(att_l), .mute_l(mute_l), .att_r(att_r), .mute_r(mute_r)
    );

    typedef struct packed {
        logic [7:0]        b;
        logic signed [17:0] s;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{8'h05, -18'sd3},
        '{8'h85,  18'sd0},
        '{8'h7F,  18'sd9},
        '{8'hC0, -18'sd1},
        '{8'h2A, -18'sd100},
        '{8'hBF,  18'sd4},
        '{8'h80, -18'sd20},
        '{8'h40,  18'sd0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_both(input string tag);
        check({tag, " left"},  {mute_l, att_l}, exp_l);
        check({tag, " right"}, {mute_r, att_r}, exp_r);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            ctl_sdi = b[i];
            tick(3);
            ctl_sck = 1'b1;
            tick(3);
            ctl_sck = 1'b0;
        end
    endtask

    task automatic latch();
        tick(2);
        ctl_stb = 1'b1;
        tick(4);
        ctl_stb = 1'b0;
        tick(6);
    endtask

    task automatic write(input logic [7:0] b);
        send_bits(b, 8);
        latch();
    endtask

    task automatic frame();
        frame_clk = ~frame_clk;
        tick(6);
    endtask

    task automatic sample(input logic right, input logic signed [17:0] v);
        smp_right = right;
        smp_data  = v;
        smp_valid = 1'b1;
        tick(1);
        smp_valid = 1'b0;
        tick(2);
    endtask

    task automatic run_samples(input logic right, input logic signed [17:0] v, input int n);
        for (int k = 0; k < n; k++) begin
            smp_right = right;
            smp_data  = v;
            smp_valid = 1'b1;
            tick(1);
        end
        smp_valid = 1'b0;
        tick(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog all requirements actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(4);
        check_both("R4 reset defaults");

        // Table: R1 R3 R5 R6 over several bytes, values and channels
        for (int i = 0; i < 8; i++) begin
            sample(VEC[i].b[7], 18'sd5);
            write(VEC[i].b);
            check_both("R5 no change before frame edge");
            frame();
            sample(VEC[i].b[7], VEC[i].s);
            if (VEC[i].s <= 0) begin
                if (VEC[i].b[7]) exp_r = VEC[i].b[6:0];
                else             exp_l = VEC[i].b[6:0];
            end
            check_both("R1 R3 R6 table vector");
        end

        // R2: a strobe after only five bits is ignored (left prev = 0 -> sign pos)
        send_bits(8'hFF, 5);
        latch();
        frame();
        sample(1'b0, -18'sd5);
        check_both("R2 short byte ignored");

        // R1/R2: sixteen bits, the last eight are committed
        send_bits(8'h9F, 8);
        send_bits(8'h12, 8);
        latch();
        frame();
        sample(1'b0, 18'sd7);
        exp_l = 7'h12;
        check_both("R1 last eight bits kept");

        // R5: crossings before the frame edge do not apply
        write(8'h8A);
        sample(1'b1, -18'sd1);
        sample(1'b1, 18'sd1);
        check_both("R5 crossings before frame ignored");
        frame();
        sample(1'b1, -18'sd1);
        exp_r = 7'h0A;
        check_both("R5 applied after frame edge");

        // R7: timeout on the 1024th sample
        write(8'h0C);
        frame();
        run_samples(1'b0, 18'sd100, 1023);
        check_both("R7 no change at 1023 samples");
        sample(1'b0, 18'sd100);
        exp_l = 7'h0C;
        check_both("R7 applied at 1024th sample");

        // R8: a new commit restarts the wait
        write(8'h91);
        frame();
        run_samples(1'b1, -18'sd50, 600);
        write(8'h92);
        check_both("R8 recommit holds old value");
        frame();
        run_samples(1'b1, -18'sd50, 600);
        check_both("R8 count restarted");
        run_samples(1'b1, -18'sd50, 423);
        check_both("R8 1023 after rearm");
        sample(1'b1, -18'sd50);
        exp_r = 7'h12;
        check_both("R8 applied at restarted timeout");

        // R6: the other channel's crossing does not apply a pending setting
        write(8'h15);
        frame();
        sample(1'b1, 18'sd5);
        check_both("R6 other channel crossing ignored");
        sample(1'b0, -18'sd3);
        exp_l = 7'h15;
        check_both("R6 own crossing applies");

        // R9: external mute
        mute_pin = 1'b1;
        tick(6);
        check("R9 mute pin left",  {mute_l, att_l}, {1'b1, exp_l[5:0]});
        check("R9 mute pin right", {mute_r, att_r}, {1'b1, exp_r[5:0]});
        mute_pin = 1'b0;
        tick(6);
        check_both("R9 mute pin released");

        // R4: reset mid-run
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(4);
        exp_l = '0;
        exp_r = '0;
        check_both("R4 reset mid run");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule